// File: doc/BRIEF.md
# Oversampled data recovery selector

This block recovers a serial bit stream that arrives without a clock. Per fast clock cycle, which spans two bit intervals, it takes eight samples. These come from four evenly spaced clock phases applied to two copies of the line. One copy is taken directly. The other is delayed by an eighth of the clock period, which is a quarter of a bit. The block registers the samples and XOR-compares pairs that lie a quarter bit apart. The results are four edge flags that show where the data transitions sit inside the sampling window.

A four-state ring tracks the edge position and selects the pair of samples farthest from it. Each output cycle carries two recovered bits. When the selection wraps around the ring, a cycle carries one bit instead, or three bits with one taken from the previous sample set. This absorbs the frequency offset between the line and the local clock. Downstream logic collects the bits using the count and valid strobe.

Top module: `ovs_data_recovery`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `vld_o` is 0, `cnt_o` is 0 and `bits_o` is 0. Reset puts the selection at state 00.
- R2: A sample set presented at the inputs before clock edge n affects the outputs after edge n+1. The inputs pass through one register stage, then the output register.
- R3: The master bits are M1..M4 = `mst_smp_i[0..3]` and the slave bits are S1..S4 = `slv_smp_i[0..3]`. The edge flags are F0=(M1^S1)|(M2^S2), F1=(M3^S1)|(M4^S2), F2=(M2^S3)|(M4^S4) and F3=(M1^S4')|(M2^S3), where S4' is S4 from the previous sample set.
- R4: With no edge flag set, the selection stays where it is and two bits are output.
- R5: The ring order is 00, 01, 11, 10, back to 00, with positions p=0..3 in that order. If only the flag F[(p+3) mod 4] is set, the selection moves one step forward.
- R6: If only the flag F[(p+1) mod 4] is set, the selection moves one step backward.
- R7: If more than one flag is set, or the single set flag is neither of the two above, the selection does not change.
- R8: The selection decides which samples are output, in time order. State 00 outputs S1 then S2. State 01 outputs M1 then M2. State 11 outputs S3 then S4. State 10 outputs M3 then M4. The output uses the state reached in that same cycle.
- R9: A step from 10 to 00 outputs one bit only, which is S2.
- R10: A step from 00 to 10 outputs three bits, in time order: M4 of the previous sample set, then M3, then M4.
- R11: `bits_o[0]` is the earliest bit. Unused upper bits are 0. `cnt_o` gives the number of valid bits (1, 2 or 3) whenever `vld_o` is 1. After the first cycle out of reset, `vld_o` is 1 on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mst_smp_i | input | 4 | Samples of the direct line copy, phases 0/180/90/270 degrees on bits 0..3 |
| slv_smp_i | input | 4 | Samples of the delayed line copy, same phase order |
| bits_o | output | 3 | Recovered bits, bit 0 earliest |
| cnt_o | output | 2 | Number of valid bits in `bits_o` |
| vld_o | output | 1 | Output word valid |

## Verification
Some properties are checked by assertions on every cycle:
- The selection only changes by one ring step at a time.
- The selection holds whenever several flags fire together.
- A count of one or three only appears on the matching wrap transition.
- The count stays legal while the output is valid.

Other behaviour only shows up in the bench scenarios:
- That the flags are the right XOR pairs, including the use of the previous set's slave sample.
- Which samples are selected in each state.
- The bit order of the three-bit word.

The bench predicts these from the requirements and compares the full output word on each cycle.

// File: rtl/ovs_dru_pkg.sv
package ovs_dru_pkg;

   typedef enum logic [1:0] {
      SEL_A = 2'b00,
      SEL_B = 2'b01,
      SEL_C = 2'b11,
      SEL_D = 2'b10
   } sel_e;

   localparam int RING_LEN = 4;
   localparam int OUT_MAX  = 3;

   function automatic logic [1:0] sel_pos(input sel_e s);
      case (s)
         SEL_A:   return 2'd0;
         SEL_B:   return 2'd1;
         SEL_C:   return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   function automatic sel_e pos_sel(input logic [1:0] p);
      case (p)
         2'd0:    return SEL_A;
         2'd1:    return SEL_B;
         2'd2:    return SEL_C;
         default: return SEL_D;
      endcase
   endfunction

endpackage

// File: rtl/ovs_smp_stage.sv
module ovs_smp_stage #(
   parameter int SMP_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SMP_W-1:0] m_i,
   input  logic [SMP_W-1:0] s_i,
   output logic [SMP_W-1:0] m_o,
   output logic [SMP_W-1:0] s_o,
   output logic             m_last_o,
   output logic             s_last_o,
   output logic             ok_o
);
   localparam int TOP = SMP_W - 1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_o      <= '0;
         s_o      <= '0;
         m_last_o <= 1'b0;
         s_last_o <= 1'b0;
         ok_o     <= 1'b0;
      end else begin
         m_last_o <= m_o[TOP];
         s_last_o <= s_o[TOP];
         m_o      <= m_i;
         s_o      <= s_i;
         ok_o     <= 1'b1;
      end
   end

   // R2: the held samples are the inputs of the previous edge
   AST_STAGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ok_o |=> s_last_o == $past(s_o[TOP])); // R3

endmodule

// File: rtl/ovs_edge_flags.sv
module ovs_edge_flags #(
   parameter int SMP_W = 4,
   parameter int FLG_N = 4
) (
   input  logic [SMP_W-1:0] m_i,
   input  logic [SMP_W-1:0] s_i,
   input  logic             s_last_i,
   output logic [FLG_N-1:0] flg_o
);
   // sample positions within one fast clock period
   localparam int P0   = 0;
   localparam int P180 = 1;
   localparam int P90  = 2;
   localparam int P270 = 3;

   logic [FLG_N-1:0] lo_cmp, hi_cmp;

   always_comb begin
      lo_cmp[0] = m_i[P0]   ^ s_i[P0];
      hi_cmp[0] = m_i[P180] ^ s_i[P180];
      lo_cmp[1] = m_i[P90]  ^ s_i[P0];
      hi_cmp[1] = m_i[P270] ^ s_i[P180];
      lo_cmp[2] = m_i[P180] ^ s_i[P90];
      hi_cmp[2] = m_i[P270] ^ s_i[P270];
      lo_cmp[3] = m_i[P0]   ^ s_last_i;
      hi_cmp[3] = m_i[P180] ^ s_i[P90];
   end

   for (genvar g = 0; g < FLG_N; g++) begin : g_flag
      assign flg_o[g] = lo_cmp[g] | hi_cmp[g];
   end

endmodule

// File: rtl/ovs_track_fsm.sv
module ovs_track_fsm
   import ovs_dru_pkg::*;
#(
   parameter int FLG_N = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [FLG_N-1:0] flg_i,
   output sel_e             cur_o,
   output sel_e             nxt_o
);
   localparam logic [1:0] FWD_OFS = 2'd3;
   localparam logic [1:0] BCK_OFS = 2'd1;

   logic [1:0] pos;
   logic       adv, ret, single;

   always_comb begin
      pos    = sel_pos(cur_o);
      adv    = flg_i[pos + FWD_OFS];
      ret    = flg_i[pos + BCK_OFS];
      single = ($countones(flg_i) == 1);
      nxt_o  = cur_o;
      if (en_i && single) begin
         if (adv)      nxt_o = pos_sel(pos + 2'd1);
         else if (ret) nxt_o = pos_sel(pos - 2'd1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cur_o <= SEL_A;
      else        cur_o <= nxt_o;
   end

   AST_HOLD_ON_MULTI: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $countones(flg_i) > 1) |=> $stable(cur_o)); // R7

   AST_ONE_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(cur_o ^ $past(cur_o)) <= 1); // R5

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_i == '0) |=> $stable(cur_o)); // R4

endmodule

// File: rtl/ovs_bit_pick.sv
module ovs_bit_pick
   import ovs_dru_pkg::*;
#(
   parameter int SMP_W = 4,
   parameter int OUT_W = 3,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  sel_e             cur_i,
   input  sel_e             nxt_i,
   input  logic [SMP_W-1:0] m_i,
   input  logic [SMP_W-1:0] s_i,
   input  logic             m_last_i,
   output logic [OUT_W-1:0] bits_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             vld_o
);
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TWO = CNT_W'(2);
   localparam logic [CNT_W-1:0] CNT_TRI = CNT_W'(3);

   logic             early, late;
   logic             drop, add;
   logic [OUT_W-1:0] word;
   logic [CNT_W-1:0] num;

   always_comb begin
      case (nxt_i)
         SEL_A:   begin early = s_i[0]; late = s_i[1]; end
         SEL_B:   begin early = m_i[0]; late = m_i[1]; end
         SEL_C:   begin early = s_i[2]; late = s_i[3]; end
         default: begin early = m_i[2]; late = m_i[3]; end
      endcase
      drop = (cur_i == SEL_D) && (nxt_i == SEL_A);
      add  = (cur_i == SEL_A) && (nxt_i == SEL_D);
      word = '0;
      if (drop) begin
         word[0] = late;
         num     = CNT_ONE;
      end else if (add) begin
         word[0] = m_last_i;
         word[1] = early;
         word[2] = late;
         num     = CNT_TRI;
      end else begin
         word[0] = early;
         word[1] = late;
         num     = CNT_TWO;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_o <= '0;
         cnt_o  <= '0;
         vld_o  <= 1'b0;
      end else if (en_i) begin
         bits_o <= word;
         cnt_o  <= num;
         vld_o  <= 1'b1;
      end else begin
         bits_o <= '0;
         cnt_o  <= '0;
         vld_o  <= 1'b0;
      end
   end

   AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !vld_o |-> (cnt_o == '0 && bits_o == '0)); // R11

   AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |-> cnt_o != '0); // R11

endmodule

// File: rtl/ovs_data_recovery.sv
module ovs_data_recovery
   import ovs_dru_pkg::*;
#(
   parameter int SMP_W = 4,
   parameter int OUT_W = 3,
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SMP_W-1:0] mst_smp_i,
   input  logic [SMP_W-1:0] slv_smp_i,
   output logic [OUT_W-1:0] bits_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic             vld_o
);
   localparam int FLG_N = RING_LEN;

   if (SMP_W != 4) begin : g_bad_smp
      $error("ovs_data_recovery: SMP_W must be 4");
   end
   if (OUT_W != OUT_MAX) begin : g_bad_out
      $error("ovs_data_recovery: OUT_W must be 3");
   end
   if ((1 << CNT_W) <= OUT_W) begin : g_bad_cnt
      $error("ovs_data_recovery: CNT_W too narrow for OUT_W");
   end

   logic [SMP_W-1:0] m_q, s_q;
   logic             m_last, s_last, ok;
   logic [FLG_N-1:0] flg;
   sel_e             sel_cur, sel_nxt;

   ovs_smp_stage #(.SMP_W(SMP_W)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .m_i      (mst_smp_i),
      .s_i      (slv_smp_i),
      .m_o      (m_q),
      .s_o      (s_q),
      .m_last_o (m_last),
      .s_last_o (s_last),
      .ok_o     (ok)
   );

   ovs_edge_flags #(.SMP_W(SMP_W), .FLG_N(FLG_N)) u_flags (
      .m_i      (m_q),
      .s_i      (s_q),
      .s_last_i (s_last),
      .flg_o    (flg)
   );

   ovs_track_fsm #(.FLG_N(FLG_N)) u_fsm (
      .clk   (clk),
      .rst_n (rst_n),
      .en_i  (ok),
      .flg_i (flg),
      .cur_o (sel_cur),
      .nxt_o (sel_nxt)
   );

   ovs_bit_pick #(.SMP_W(SMP_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) u_pick (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (ok),
      .cur_i    (sel_cur),
      .nxt_i    (sel_nxt),
      .m_i      (m_q),
      .s_i      (s_q),
      .m_last_i (m_last),
      .bits_o   (bits_o),
      .cnt_o    (cnt_o),
      .vld_o    (vld_o)
   );

   AST_ONE_BIT_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && cnt_o == CNT_W'(1)) |-> (sel_cur == SEL_A && $past(sel_cur) == SEL_D)); // R9

   AST_THREE_BITS_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_o && cnt_o == CNT_W'(3)) |-> (sel_cur == SEL_D && $past(sel_cur) == SEL_A)); // R10

   AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      vld_o |=> vld_o); // R11

endmodule

// File: tb/ovs_data_recovery_bench.sv
`timescale 1ns/1ps
module ovs_data_recovery_bench;

   localparam int NV = 28;
   // each entry: {master[3:0], slave[3:0]}
   localparam logic [7:0] VEC [NV] = '{
      8'h00, 8'h40, 8'h00, 8'hA6, 8'h00, 8'hFF, 8'h00, 8'h10,
      8'h3C, 8'hC3, 8'h5A, 8'h96, 8'h0F, 8'hF0, 8'h11, 8'h22,
      8'h44, 8'h88, 8'h77, 8'hEE, 8'h00, 8'h40, 8'h00, 8'hA6,
      8'hFF, 8'h00, 8'hFF, 8'h00
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] mst = '0, slv = '0;
   logic [2:0] bits;
   logic [1:0] cnt;
   logic       vld;

   int total = 0, fails = 0;
   bit done = 0;

   // model state
   logic [3:0] q_m, q_s;
   logic       q_ok, q_ml, q_sl;
   logic [1:0] pos;
   logic [5:0] exp_w;
   string      exp_tag;

   always #4 clk = ~clk;

   ovs_data_recovery u_ovs_data_recovery (
      .clk(clk), .rst_n(rst_n), .mst_smp_i(mst), .slv_smp_i(slv),
      .bits_o(bits), .cnt_o(cnt), .vld_o(vld)
   );

   task automatic check(input string tag, input logic [5:0] act, input logic [5:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: {vld,cnt,bits} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      q_m = '0; q_s = '0; q_ok = 0; q_ml = 0; q_sl = 0; pos = 2'd0;
      exp_w = '0; exp_tag = "R1";
   endtask

   // R3 flags, R5/R6/R7 stepping, R8 pair choice, R9/R10/R11 packing
   task automatic model_step(input logic [3:0] nm, input logic [3:0] ns);
      logic [3:0] f;
      logic [1:0] np;
      logic       e, l;
      f[0] = (q_m[0]^q_s[0]) | (q_m[1]^q_s[1]);
      f[1] = (q_m[2]^q_s[0]) | (q_m[3]^q_s[1]);
      f[2] = (q_m[1]^q_s[2]) | (q_m[3]^q_s[3]);
      f[3] = (q_m[0]^q_sl)   | (q_m[1]^q_s[2]);
      np = pos;
      exp_tag = "R4";
      if ($countones(f) > 1) exp_tag = "R7";
      else if (f[(pos+3)%4]) begin np = 2'((pos+1)%4); exp_tag = "R5"; end
      else if (f[(pos+1)%4]) begin np = 2'((pos+3)%4); exp_tag = "R6"; end
      case (np)
         2'd0: begin e = q_s[0]; l = q_s[1]; end
         2'd1: begin e = q_m[0]; l = q_m[1]; end
         2'd2: begin e = q_s[2]; l = q_s[3]; end
         default: begin e = q_m[2]; l = q_m[3]; end
      endcase
      if (!q_ok) begin
         exp_w = '0; exp_tag = "R2";
      end else begin
         if (pos == 2'd3 && np == 2'd0) begin exp_w = {1'b1, 2'd1, 2'b00, l}; exp_tag = "R9"; end
         else if (pos == 2'd0 && np == 2'd3) begin exp_w = {1'b1, 2'd3, l, e, q_ml}; exp_tag = "R10"; end
         else exp_w = {1'b1, 2'd2, 1'b0, l, e};
         pos = np;
      end
      q_ml = q_m[3]; q_sl = q_s[3];
      q_m = nm; q_s = ns; q_ok = 1;
   endtask

   task automatic step(input logic [3:0] nm, input logic [3:0] ns);
      @(negedge clk);
      check(exp_tag, {vld, cnt, bits}, exp_w);
      model_step(nm, ns);
      mst = nm; slv = ns;
   endtask

   task automatic apply_reset();
      @(negedge clk);
      rst_n = 0; mst = '0; slv = '0;
      model_reset();
      repeat (2) @(negedge clk);
      check("R1", {vld, cnt, bits}, 6'b0);
      rst_n = 1;
      check("R1", {vld, cnt, bits}, 6'b0);
   endtask

   initial begin
      model_reset();
      apply_reset();
      // first cycle out of reset is still quiet (R1, R2)
      model_step(VEC[0][7:4], VEC[0][3:0]);
      mst = VEC[0][7:4]; slv = VEC[0][3:0];
      // table walk: every row checks the full output word
      for (int i = 1; i < NV; i++) step(VEC[i][7:4], VEC[i][3:0]);
      step(4'h0, 4'h0);
      step(4'h0, 4'h0);

      // directed: reset mid-run returns selection to state 00 (R1)
      apply_reset();
      model_step(4'h0, 4'h3);
      mst = 4'h0; slv = 4'h3;
      step(4'h0, 4'h0);   // R7 multi-flag hold, pair S1/S2 shows state 00
      step(4'h0, 4'h0);
      // directed: positive wrap then negative wrap (R10, R9)
      step(4'h4, 4'h0);
      step(4'h0, 4'h0);
      step(4'hA, 4'h6);
      step(4'h0, 4'h0);
      step(4'h0, 4'h0);
      step(4'h0, 4'h0);

      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

endmodule